// File: doc/BRIEF.md
# Keyboard Serial Receiver with Release Filtering

This block listens to the two-wire serial link of a keyboard (a clock line and a data line, both driven by the keyboard and idle high). It brings both lines into the system clock domain, filters short glitches off the keyboard clock, and samples the data line on each falling edge of the filtered clock. Each frame is checked for a low start bit, odd parity over the data byte and parity bit, and a high stop bit. The data byte arrives least-significant bit first.

Valid bytes pass through a release filter. The byte 0xF0 marks a key release and arms the filter. The byte that comes next names the released key and is discarded. All other valid bytes are key presses. Each one is reported as a single-cycle strobe together with the byte. A malformed frame is dropped and gives a single-cycle error strobe instead. If the keyboard clock stops in the middle of a frame for longer than a timeout, the partial frame is abandoned and the receiver waits for a new start bit.

Top module: `ps2_make_rx`

## Requirements
- R1: After reset, `key_valid` and `frame_err` are low and no byte is pending.
- R2: A well-formed frame carrying a byte other than 0xF0, when not preceded by 0xF0, gives exactly one `key_valid` pulse with `key_code` equal to the byte. The bits are taken least-significant first.
- R3: A well-formed frame carrying 0xF0 produces no `key_valid` pulse.
- R4: The well-formed byte that directly follows 0xF0 produces no `key_valid` pulse, and the byte after it is reported normally.
- R5: A frame whose eight data bits plus parity bit hold an even number of ones is dropped with one `frame_err` pulse and no `key_valid`.
- R6: A frame whose start bit is 1 is dropped with one `frame_err` pulse and no `key_valid`.
- R7: A frame whose stop bit is 0 is dropped with one `frame_err` pulse and no `key_valid`.
- R8: A low pulse on the keyboard clock that lasts fewer than `FILTER_LEN` system cycles is ignored, so the next frame decodes correctly.
- R9: If no falling edge arrives for `TIMEOUT` cycles in the middle of a frame, the partial frame is discarded without an error pulse, and the next full frame decodes correctly.
- R10: `key_valid` and `frame_err` are each high for one cycle per frame and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk | input | 1 | Keyboard clock line, asynchronous |
| ps2_data | input | 1 | Keyboard data line, asynchronous |
| key_valid | output | 1 | One-cycle strobe for a key press |
| key_code | output | 8 | Make-code byte, valid while `key_valid` is high |
| frame_err | output | 1 | One-cycle strobe for a dropped frame |

## Verification
Every byte value except 0xF0 is sent as a press. This separates correct bit order and full byte capture from swapped or stuck bits, because each code must come back unchanged with exactly one strobe. Release sequences, two presses in a row, and a release followed by a press check that the filter swallows exactly one byte after the prefix and then clears. Frames with a corrupted parity, start or stop bit must each give an error and no key. A short clock glitch and an abandoned half frame must leave the next frame aligned.

// File: rtl/ps2_make_rx.sv
module ps2_make_rx #(
  parameter int FILTER_LEN = 8,
  parameter int TIMEOUT    = 37500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk,
  input  logic       ps2_data,
  output logic       key_valid,
  output logic [7:0] key_code,
  output logic       frame_err
);
  localparam int FW = $clog2(FILTER_LEN + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [7:0] RELEASE = 8'hF0;

  logic [1:0]    ck_s, dt_s;
  logic [FW-1:0] fcnt;
  logic          ck_f, ck_q;
  logic [3:0]    bitcnt;
  logic [9:0]    sh;
  logic [TW-1:0] tcnt;
  logic          brk;

  wire fall     = ck_q & ~ck_f;
  wire stop_bit = dt_s[1];
  wire frame_ok = ~sh[0] & stop_bit & (^sh[9:1]);
  wire [7:0] data_byte = sh[8:1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= 2'b11;
      dt_s <= 2'b11;
    end else begin
      ck_s <= {ck_s[0], ps2_clk};
      dt_s <= {dt_s[0], ps2_data};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fcnt <= '0;
      ck_f <= 1'b1;
      ck_q <= 1'b1;
    end else begin
      ck_q <= ck_f;
      if (ck_s[1] == ck_f)
        fcnt <= '0;
      else if (fcnt == FW'(FILTER_LEN - 1)) begin
        ck_f <= ck_s[1];
        fcnt <= '0;
      end else
        fcnt <= fcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt    <= '0;
      sh        <= '0;
      tcnt      <= '0;
      brk       <= 1'b0;
      key_valid <= 1'b0;
      key_code  <= '0;
      frame_err <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      frame_err <= 1'b0;
      if (fall) begin
        tcnt <= '0;
        if (bitcnt == 4'd10) begin
          bitcnt <= '0;
          if (!frame_ok)
            frame_err <= 1'b1;
          else if (data_byte == RELEASE)
            brk <= 1'b1;
          else if (brk)
            brk <= 1'b0;
          else begin
            key_valid <= 1'b1;
            key_code  <= data_byte;
          end
        end else begin
          sh     <= {dt_s[1], sh[9:1]};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (bitcnt != 4'd0) begin
        if (tcnt == TW'(TIMEOUT - 1)) begin
          bitcnt <= '0;
          tcnt   <= '0;
        end else
          tcnt <= tcnt + 1'b1;
      end
    end

  assert_key_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid && frame_err));
  assert_no_release_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_code != RELEASE);
  assert_key_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(fall));
  assert_bitcnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd10);
endmodule

// File: tb/tb_ps2_make_rx.sv
module tb_ps2_make_rx;
  localparam int FL   = 4;
  localparam int TO   = 200;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2_clk = 1'b1;
  logic ps2_data = 1'b1;
  logic key_valid, frame_err;
  logic [7:0] key_code;

  int checks = 0, errors = 0, nkeys = 0, nerrs = 0;
  logic [7:0] lastk = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;

  ps2_make_rx #(.FILTER_LEN(FL), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_data(ps2_data),
    .key_valid(key_valid), .key_code(key_code), .frame_err(frame_err));

  always @(negedge clk) begin
    if (key_valid) begin nkeys++; lastk = key_code; end
    if (frame_err) nerrs++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par,
                      input logic sv, input logic pv, input int nbits);
    logic [10:0] f;
    f = {pv, (~^b) ^ bad_par, b, sv};
    for (int i = 0; i < nbits; i++) begin
      ps2_data = f[i];
      wait_cyc(HALF / 2);
      ps2_clk = 1'b0;
      wait_cyc(HALF);
      ps2_clk = 1'b1;
      wait_cyc(HALF / 2);
    end
    ps2_data = 1'b1;
    wait_cyc(4 * HALF);
  endtask

  task automatic expect_frame(input string tag, input int k0, input int e0,
                              input int dk, input int de, input logic [7:0] code);
    checks++;
    if (nkeys - k0 != dk || nerrs - e0 != de || (dk == 1 && lastk != code)) begin
      errors++;
      $display("FAIL %s: keys %0d errs %0d code %02h, expected keys %0d errs %0d code %02h",
               tag, nkeys - k0, nerrs - e0, lastk, dk, de, code);
    end
  endtask

  task automatic frame_chk(input string tag, input logic [7:0] b, input bit bp,
                           input logic sv, input logic pv, input int dk,
                           input int de);
    int k0, e0;
    k0 = nkeys; e0 = nerrs;
    send(b, bp, sv, pv, 11);
    expect_frame(tag, k0, e0, dk, de, b);
  endtask

  initial begin
    wait_cyc(5);
    checks++;
    if (key_valid !== 1'b0 || frame_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid %b err %b, expected 0 0", key_valid, frame_err);
    end
    rst_n = 1'b1;
    wait_cyc(5);
    checks++;
    if (key_valid !== 1'b0 || frame_err !== 1'b0 || nkeys != 0) begin
      errors++;
      $display("FAIL R1: valid %b err %b keys %0d, expected 0 0 0", key_valid, frame_err, nkeys);
    end

    for (int c = 0; c < 256; c++)
      if (c != 8'hF0) frame_chk("R2 sweep", 8'(c), 1'b0, 1'b0, 1'b1, 1, 0);

    frame_chk("R2 press 1C", 8'h1C, 1'b0, 1'b0, 1'b1, 1, 0);
    frame_chk("R2 press 32", 8'h32, 1'b0, 1'b0, 1'b1, 1, 0);
    frame_chk("R3 prefix", 8'hF0, 1'b0, 1'b0, 1'b1, 0, 0);
    frame_chk("R4 swallowed", 8'h31, 1'b0, 1'b0, 1'b1, 0, 0);
    frame_chk("R4 after release", 8'h31, 1'b0, 1'b0, 1'b1, 1, 0);
    frame_chk("R3 prefix again", 8'hF0, 1'b0, 1'b0, 1'b1, 0, 0);
    frame_chk("R4 swallowed 1C", 8'h1C, 1'b0, 1'b0, 1'b1, 0, 0);
    frame_chk("R4 next press", 8'h1C, 1'b0, 1'b0, 1'b1, 1, 0);

    frame_chk("R5 bad parity", 8'h31, 1'b1, 1'b0, 1'b1, 0, 1);
    frame_chk("R5 bad parity 00", 8'h00, 1'b1, 1'b0, 1'b1, 0, 1);
    frame_chk("R6 bad start", 8'h31, 1'b0, 1'b1, 1'b1, 0, 1);
    frame_chk("R7 bad stop", 8'h31, 1'b0, 1'b0, 1'b0, 0, 1);
    frame_chk("R5 recovery", 8'h4D, 1'b0, 1'b0, 1'b1, 1, 0);

    ps2_clk = 1'b0; wait_cyc(FL - 2); ps2_clk = 1'b1; wait_cyc(20);
    frame_chk("R8 after glitch", 8'h2A, 1'b0, 1'b0, 1'b1, 1, 0);

    begin
      int k0, e0;
      k0 = nkeys; e0 = nerrs;
      send(8'h55, 1'b0, 1'b0, 1'b1, 5);
      wait_cyc(TO + 50);
      expect_frame("R9 partial dropped", k0, e0, 0, 0, 8'h00);
    end
    frame_chk("R9 next frame", 8'h3B, 1'b0, 1'b0, 1'b1, 1, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule